// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level translation structure in memory. A client hands over a request with the linear address and two flags, one for user-mode and one for write. The walker reads the top-level entry through a word-wide memory port. If that entry allows the access, it reads the second-level entry, checks it, and returns either the physical address or a fault.

The physical base of the top-level table is taken from a base input when the request is accepted. Both levels use 4 KB tables of 1024 four-byte entries. On a successful walk, any entry whose accessed flag was clear is rewritten with the flag set, and a write access also marks the leaf entry dirty. These read-modify-write updates finish before the response is presented. The walker handles one request at a time: it takes a new one only after the previous response has been consumed.

Top module: `pt_walker`

## Requirements
- R1: On success the physical address is bits 31:12 of the leaf entry joined with linear address bits 11:0. Example: linear 0x801C3400, top entry 0x000E4007, leaf entry 0x00028007 gives 0x00028400.
- R2: The first read goes to the latched base plus four times linear bits 31:22. The second read goes to {top entry bits 31:12, 12'h000} plus four times linear bits 21:12.
- R3: An entry with bit 0 (present) clear ends the walk with fault cause 1 (not-present). The level flag is 0 for the top entry and 1 for the leaf, no further memory access follows, and the other 31 bits of that entry have no effect.
- R4: A user access needs bit 2 (user-allowed) set in both entries. Otherwise the fault cause is 2 (privilege), reported at the first level that denies it. Supervisor accesses ignore bit 2.
- R5: A user write needs bit 1 (writable) set in both entries. Otherwise the fault cause is 3 (write-protect). Privilege takes priority over write-protect at the same level. Supervisor writes ignore bit 1.
- R6: On success, each entry with bit 5 (accessed) clear is written back with bit 5 set and all other bits unchanged, top entry first. Entries that already have the bit set are not written.
- R7: On a successful write access the leaf entry is written back with bit 6 (dirty) set if it was clear. Read accesses never set bit 6.
- R8: Every response echoes the request's linear address. A fault response carries a nonzero cause and a physical address of zero. A success carries cause 0. No entry is written back when a walk faults.
- R9: `req_ready` is high only when the walker is idle. A response stays valid and unchanged until `rsp_ready` is high, and no request is accepted while it waits.
- R10: A memory request holds its valid flag, address, write flag and data unchanged until the port accepts it, for any number of wait cycles.
- R11: After reset the walker is idle, with `req_ready` high and no memory request or response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_base_i | input | 32 | Physical base of the top-level table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 32 | Linear address to translate |
| req_user_i | input | 1 | 1 = user-mode access, 0 = supervisor |
| req_write_i | input | 1 | 1 = write access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Client takes the response |
| rsp_paddr_o | output | 32 | Physical address (zero on fault) |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_cause_o | output | 2 | 0 none, 1 not-present, 2 privilege, 3 write-protect |
| rsp_level_o | output | 1 | Faulting level: 0 top, 1 leaf |
| rsp_vaddr_o | output | 32 | Linear address of this response |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | 32 | Word byte address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 32 | Read data |

## Verification
The bench builds the walker with its default widths: 10-bit indices, a 12-bit offset and 32-bit entries. These values make the worked example address reachable, along with the last top-level slot (index 0x3FF), an offset of 0xFFF, and entries whose software bits 11:9 must come through a write-back unchanged. The vector table runs twice, first with a zero-wait memory and then with a memory that stalls both acceptance and read data. This exercises every state under back-pressure.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    // Entry flag positions (decoded by software, so positions are fixed)
    localparam int FLAG_PRESENT = 0;
    localparam int FLAG_WRITE   = 1;
    localparam int FLAG_USER    = 2;
    localparam int FLAG_ACCESS  = 5;
    localparam int FLAG_DIRTY   = 6;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_PRIV   = 2'd2,
        CAUSE_WPROT  = 2'd3
    } fault_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TOP_RD,
        ST_TOP_WAIT,
        ST_LEAF_RD,
        ST_LEAF_WAIT,
        ST_TOP_WB,
        ST_LEAF_WB,
        ST_RESP
    } walk_state_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int ENT_W = 32,
    parameter int IDX_W = 10
) (
    input  logic [ENT_W-1:0] base_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [ENT_W-1:0] addr_o
);
    localparam int SHIFT = $clog2(ENT_W / 8);

    always_comb begin
        addr_o = base_i + (ENT_W'(idx_i) << SHIFT);
    end
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_walker_pkg::*;
(
    input  logic         present_i,
    input  logic         writable_i,
    input  logic         user_ok_i,
    input  logic         user_i,
    input  logic         write_i,
    output fault_cause_e cause_o
);
    always_comb begin
        if (!present_i) begin
            cause_o = CAUSE_ABSENT;
        end else if (user_i && !user_ok_i) begin
            cause_o = CAUSE_PRIV;
        end else if (user_i && write_i && !writable_i) begin
            cause_o = CAUSE_WPROT;
        end else begin
            cause_o = CAUSE_NONE;
        end
    end
endmodule

// File: rtl/pt_entry_update.sv
module pt_entry_update
    import pt_walker_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] ent_i,
    input  logic             set_dirty_i,
    output logic [ENT_W-1:0] ent_o,
    output logic             need_wb_o
);
    always_comb begin
        ent_o = ent_i;
        ent_o[FLAG_ACCESS] = 1'b1;
        if (set_dirty_i) begin
            ent_o[FLAG_DIRTY] = 1'b1;
        end
        need_wb_o = (ent_o != ent_i);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int ENT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENT_W-1:0]           dir_base_i,
    input  logic                       req_valid_i,
    output logic                       req_ready_o,
    input  logic [2*IDX_W+OFF_W-1:0]   req_vaddr_i,
    input  logic                       req_user_i,
    input  logic                       req_write_i,
    output logic                       rsp_valid_o,
    input  logic                       rsp_ready_i,
    output logic [ENT_W-1:0]           rsp_paddr_o,
    output logic                       rsp_fault_o,
    output logic [1:0]                 rsp_cause_o,
    output logic                       rsp_level_o,
    output logic [2*IDX_W+OFF_W-1:0]   rsp_vaddr_o,
    output logic                       mem_req_valid_o,
    input  logic                       mem_req_ready_i,
    output logic                       mem_req_write_o,
    output logic [ENT_W-1:0]           mem_req_addr_o,
    output logic [ENT_W-1:0]           mem_req_wdata_o,
    input  logic                       mem_rsp_valid_i,
    input  logic [ENT_W-1:0]           mem_rsp_rdata_i
);
    localparam int VA_W    = 2 * IDX_W + OFF_W;
    localparam int FRAME_W = ENT_W - OFF_W;
    localparam int LEVELS  = 2;

    typedef struct packed {
        walk_state_e       st;
        logic [VA_W-1:0]   vaddr;
        logic              user;
        logic              write;
        logic [ENT_W-1:0]  base;
        logic [ENT_W-1:0]  top_ent;
        logic [ENT_W-1:0]  leaf_ent;
        logic              fault;
        fault_cause_e      cause;
        logic              level;
    } walk_regs_t;

    walk_regs_t q, d;

    // Per-level entry addressing and write-back value
    logic [LEVELS-1:0][ENT_W-1:0] lvl_base;
    logic [LEVELS-1:0][IDX_W-1:0] lvl_idx;
    logic [LEVELS-1:0][ENT_W-1:0] lvl_addr;
    logic [LEVELS-1:0][ENT_W-1:0] lvl_cur;
    logic [LEVELS-1:0][ENT_W-1:0] lvl_new;
    logic [LEVELS-1:0]            lvl_dirty;
    logic [LEVELS-1:0]            lvl_need;

    always_comb begin
        lvl_base[0]  = q.base;
        lvl_base[1]  = {q.top_ent[ENT_W-1:OFF_W], {OFF_W{1'b0}}};
        lvl_idx[0]   = q.vaddr[VA_W-1 -: IDX_W];
        lvl_idx[1]   = q.vaddr[OFF_W +: IDX_W];
        lvl_cur[0]   = q.top_ent;
        lvl_cur[1]   = (q.st == ST_LEAF_WAIT) ? mem_rsp_rdata_i : q.leaf_ent;
        lvl_dirty[0] = 1'b0;
        lvl_dirty[1] = q.write;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        pt_entry_addr #(
            .ENT_W (ENT_W),
            .IDX_W (IDX_W)
        ) u_addr (
            .base_i (lvl_base[g]),
            .idx_i  (lvl_idx[g]),
            .addr_o (lvl_addr[g])
        );

        pt_entry_update #(
            .ENT_W (ENT_W)
        ) u_upd (
            .ent_i       (lvl_cur[g]),
            .set_dirty_i (lvl_dirty[g]),
            .ent_o       (lvl_new[g]),
            .need_wb_o   (lvl_need[g])
        );
    end

    // Checks apply to whichever entry is arriving on the read port
    fault_cause_e rd_cause;

    pt_perm_check u_perm (
        .present_i  (mem_rsp_rdata_i[FLAG_PRESENT]),
        .writable_i (mem_rsp_rdata_i[FLAG_WRITE]),
        .user_ok_i  (mem_rsp_rdata_i[FLAG_USER]),
        .user_i     (q.user),
        .write_i    (q.write),
        .cause_o    (rd_cause)
    );

    // Next-state computation
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.vaddr = req_vaddr_i;
                    d.user  = req_user_i;
                    d.write = req_write_i;
                    d.base  = dir_base_i;
                    d.fault = 1'b0;
                    d.cause = CAUSE_NONE;
                    d.level = 1'b0;
                    d.st    = ST_TOP_RD;
                end
            end
            ST_TOP_RD: begin
                if (mem_req_ready_i) begin
                    d.st = ST_TOP_WAIT;
                end
            end
            ST_TOP_WAIT: begin
                if (mem_rsp_valid_i) begin
                    d.top_ent = mem_rsp_rdata_i;
                    if (rd_cause != CAUSE_NONE) begin
                        d.fault = 1'b1;
                        d.cause = rd_cause;
                        d.level = 1'b0;
                        d.st    = ST_RESP;
                    end else begin
                        d.st = ST_LEAF_RD;
                    end
                end
            end
            ST_LEAF_RD: begin
                if (mem_req_ready_i) begin
                    d.st = ST_LEAF_WAIT;
                end
            end
            ST_LEAF_WAIT: begin
                if (mem_rsp_valid_i) begin
                    d.leaf_ent = mem_rsp_rdata_i;
                    if (rd_cause != CAUSE_NONE) begin
                        d.fault = 1'b1;
                        d.cause = rd_cause;
                        d.level = 1'b1;
                        d.st    = ST_RESP;
                    end else if (lvl_need[0]) begin
                        d.st = ST_TOP_WB;
                    end else if (lvl_need[1]) begin
                        d.st = ST_LEAF_WB;
                    end else begin
                        d.st = ST_RESP;
                    end
                end
            end
            ST_TOP_WB: begin
                if (mem_req_ready_i) begin
                    d.st = lvl_need[1] ? ST_LEAF_WB : ST_RESP;
                end
            end
            ST_LEAF_WB: begin
                if (mem_req_ready_i) begin
                    d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready_i) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Outputs driven from registered state
    always_comb begin
        req_ready_o     = (q.st == ST_IDLE);
        mem_req_valid_o = 1'b0;
        mem_req_write_o = 1'b0;
        mem_req_addr_o  = lvl_addr[0];
        mem_req_wdata_o = '0;
        unique case (q.st)
            ST_TOP_RD: begin
                mem_req_valid_o = 1'b1;
            end
            ST_LEAF_RD: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = lvl_addr[1];
            end
            ST_TOP_WB: begin
                mem_req_valid_o = 1'b1;
                mem_req_write_o = 1'b1;
                mem_req_wdata_o = lvl_new[0];
            end
            ST_LEAF_WB: begin
                mem_req_valid_o = 1'b1;
                mem_req_write_o = 1'b1;
                mem_req_addr_o  = lvl_addr[1];
                mem_req_wdata_o = lvl_new[1];
            end
            default: begin
            end
        endcase

        rsp_valid_o = (q.st == ST_RESP);
        rsp_fault_o = q.fault;
        rsp_cause_o = q.cause;
        rsp_level_o = q.level;
        rsp_vaddr_o = q.vaddr;
        rsp_paddr_o = q.fault ? '0
                              : {q.leaf_ent[ENT_W-1 -: FRAME_W], q.vaddr[OFF_W-1:0]};
    end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int ENT_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_ready_o,
    input logic                     rsp_valid_o,
    input logic                     rsp_ready_i,
    input logic [ENT_W-1:0]         rsp_paddr_o,
    input logic                     rsp_fault_o,
    input logic [1:0]               rsp_cause_o,
    input logic [2*IDX_W+OFF_W-1:0] rsp_vaddr_o,
    input logic                     mem_req_valid_o,
    input logic                     mem_req_ready_i,
    input logic                     mem_req_write_o,
    input logic [ENT_W-1:0]         mem_req_addr_o,
    input logic [ENT_W-1:0]         mem_req_wdata_o
);
    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
        && $stable(mem_req_write_o) && $stable(mem_req_wdata_o)); // R10

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o)
        && $stable(rsp_cause_o) && $stable(rsp_fault_o) && $stable(rsp_vaddr_o)); // R9

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !req_ready_o); // R9

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && !rsp_fault_o |-> rsp_paddr_o[OFF_W-1:0] == rsp_vaddr_o[OFF_W-1:0]); // R1

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_fault_o == (rsp_cause_o != 2'd0))); // R8

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0); // R8

    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_write_o |-> mem_req_wdata_o[5] && mem_req_wdata_o[0]); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_valid_o && !rsp_valid_o); // R11
endmodule

bind pt_walker pt_walker_chk #(
    .IDX_W (IDX_W),
    .OFF_W (OFF_W),
    .ENT_W (ENT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_ready_o     (req_ready_o),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_fault_o     (rsp_fault_o),
    .rsp_cause_o     (rsp_cause_o),
    .rsp_vaddr_o     (rsp_vaddr_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_write_o (mem_req_write_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_wdata_o (mem_req_wdata_o)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

    localparam logic [31:0] TOP_BASE = 32'h0010_0000;
    localparam int NVEC = 13;

    typedef struct packed {
        logic [31:0] vaddr;
        logic        user;
        logic        write;
        logic [31:0] top;
        logic [31:0] leaf;
        logic        fault;
        logic [1:0]  cause;
        logic        level;
        logic [31:0] paddr;
        logic [31:0] top_after;
        logic [31:0] leaf_after;
    } vec_t;

    // vaddr, user, write, top, leaf, fault, cause, level, paddr, top_after, leaf_after
    localparam vec_t VECS [NVEC] = '{
        '{32'h801C3400, 1'b0, 1'b0, 32'h000E4007, 32'h00028007, 1'b0, 2'd0, 1'b0, 32'h00028400, 32'h000E4027, 32'h00028027},
        '{32'h00401ABC, 1'b1, 1'b0, 32'h000E4027, 32'h12345025, 1'b0, 2'd0, 1'b0, 32'h12345ABC, 32'h000E4027, 32'h12345025},
        '{32'h00402010, 1'b1, 1'b1, 32'h000E4027, 32'h12346025, 1'b1, 2'd3, 1'b1, 32'h00000000, 32'h000E4027, 32'h12346025},
        '{32'h00403FFF, 1'b0, 1'b1, 32'h000E4025, 32'h0ABCD005, 1'b0, 2'd0, 1'b0, 32'h0ABCDFFF, 32'h000E4025, 32'h0ABCD065},
        '{32'hFFC00000, 1'b0, 1'b0, 32'hFFFFFFFE, 32'h00000007, 1'b1, 2'd1, 1'b0, 32'h00000000, 32'hFFFFFFFE, 32'h00000007},
        '{32'h12345678, 1'b0, 1'b0, 32'h00200007, 32'h99999FFE, 1'b1, 2'd1, 1'b1, 32'h00000000, 32'h00200007, 32'h99999FFE},
        '{32'h40000123, 1'b1, 1'b0, 32'h00300023, 32'h55555027, 1'b1, 2'd2, 1'b0, 32'h00000000, 32'h00300023, 32'h55555027},
        '{32'h40001123, 1'b1, 1'b0, 32'h00300027, 32'h55555023, 1'b1, 2'd2, 1'b1, 32'h00000000, 32'h00300027, 32'h55555023},
        '{32'h40002000, 1'b1, 1'b1, 32'h00300025, 32'h55556067, 1'b1, 2'd3, 1'b0, 32'h00000000, 32'h00300025, 32'h55556067},
        '{32'h40003800, 1'b1, 1'b1, 32'h00300027, 32'h77777027, 1'b0, 2'd0, 1'b0, 32'h77777800, 32'h00300027, 32'h77777067},
        '{32'h40004004, 1'b1, 1'b1, 32'h00300027, 32'h77778067, 1'b0, 2'd0, 1'b0, 32'h77778004, 32'h00300027, 32'h77778067},
        '{32'h00805000, 1'b1, 1'b1, 32'h00400007, 32'h01000E07, 1'b0, 2'd0, 1'b0, 32'h01000000, 32'h00400027, 32'h01000E67},
        '{32'h40005000, 1'b1, 1'b1, 32'h00300021, 32'h55559067, 1'b1, 2'd2, 1'b0, 32'h00000000, 32'h00300021, 32'h55559067}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        rsp_level;
    logic [31:0] rsp_vaddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #5 clk = ~clk;

    pt_walker uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .dir_base_i      (TOP_BASE),
        .req_valid_i     (req_valid),
        .req_ready_o     (req_ready),
        .req_vaddr_i     (req_vaddr),
        .req_user_i      (req_user),
        .req_write_i     (req_write),
        .rsp_valid_o     (rsp_valid),
        .rsp_ready_i     (rsp_ready),
        .rsp_paddr_o     (rsp_paddr),
        .rsp_fault_o     (rsp_fault),
        .rsp_cause_o     (rsp_cause),
        .rsp_level_o     (rsp_level),
        .rsp_vaddr_o     (rsp_vaddr),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_ready_i (mem_req_ready),
        .mem_req_write_o (mem_req_write),
        .mem_req_addr_o  (mem_req_addr),
        .mem_req_wdata_o (mem_req_wdata),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_rdata_i (mem_rsp_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: word store, logs, stall pattern
    logic [31:0] mem [logic [31:0]];
    bit          var_wait = 1'b0;
    logic [7:0]  lfsr = 8'h5A;
    int          acc_wait = 0;
    int          rd_wait = 0;
    bit          rd_pend = 1'b0;
    logic [31:0] rd_addr = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] rd_log [4];
    logic [31:0] wr_log [4];
    bit          prev_v = 1'b0;
    bit          prev_r = 1'b0;
    logic [31:0] prev_a = '0;
    int          stab_err = 0;

    always @(negedge clk) begin
        if (prev_v && !prev_r && (!mem_req_valid || mem_req_addr != prev_a)) stab_err++;
        mem_rsp_valid = 1'b0;
        if (rd_pend) begin
            if (rd_wait == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
                rd_pend = 1'b0;
            end else begin
                rd_wait--;
            end
        end
        mem_req_ready = 1'b0;
        if (mem_req_valid && !rd_pend) begin
            if (acc_wait == 0) begin
                mem_req_ready = 1'b1;
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                acc_wait = var_wait ? int'(lfsr[1:0]) : 0;
                if (mem_req_write) begin
                    mem[mem_req_addr] = mem_req_wdata;
                    if (wr_cnt < 4) wr_log[wr_cnt] = mem_req_addr;
                    wr_cnt++;
                end else begin
                    rd_pend = 1'b1;
                    rd_addr = mem_req_addr;
                    rd_wait = var_wait ? int'(lfsr[3:2]) : 0;
                    if (rd_cnt < 4) rd_log[rd_cnt] = mem_req_addr;
                    rd_cnt++;
                end
            end else begin
                acc_wait--;
            end
        end
        prev_v = mem_req_valid;
        prev_r = mem_req_ready;
        prev_a = mem_req_addr;
    end

    function automatic logic [31:0] top_addr(input logic [31:0] va);
        return TOP_BASE + {20'h0, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] leaf_addr(input logic [31:0] top, input logic [31:0] va);
        return {top[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    endfunction

    task automatic setup_vec(input vec_t v);
        mem[top_addr(v.vaddr)] = v.top;
        mem[leaf_addr(v.top, v.vaddr)] = v.leaf;
        rd_cnt = 0;
        wr_cnt = 0;
    endtask

    task automatic issue(input logic [31:0] va, input logic user, input logic wr);
        req_valid = 1'b1;
        req_vaddr = va;
        req_user  = user;
        req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] ta;
        logic [31:0] la;
        int          exp_rd;
        int          exp_wr;
        ta = top_addr(v.vaddr);
        la = leaf_addr(v.top, v.vaddr);
        setup_vec(v);
        issue(v.vaddr, v.user, v.write);
        while (!rsp_valid) @(negedge clk);
        // R3 R4 R5: fault kind and level; R8: zero address and echo
        chk_eq($sformatf("R3/R4/R5 fault flag vec %0d", idx), {31'h0, rsp_fault}, {31'h0, v.fault});
        chk_eq($sformatf("R3/R4/R5 cause vec %0d", idx), {30'h0, rsp_cause}, {30'h0, v.cause});
        if (v.fault) chk_eq($sformatf("R3 level vec %0d", idx), {31'h0, rsp_level}, {31'h0, v.level});
        chk_eq($sformatf("R1 paddr vec %0d", idx), rsp_paddr, v.paddr);
        chk_eq($sformatf("R8 vaddr echo vec %0d", idx), rsp_vaddr, v.vaddr);
        @(negedge clk);
        exp_rd = (v.fault && !v.level) ? 1 : 2;
        chk_eq($sformatf("R3 read count vec %0d", idx), rd_cnt, exp_rd);
        chk_eq($sformatf("R2 top read addr vec %0d", idx), rd_log[0], ta);
        if (exp_rd == 2) chk_eq($sformatf("R2 leaf read addr vec %0d", idx), rd_log[1], la);
        exp_wr = int'(v.top != v.top_after) + int'(v.leaf != v.leaf_after);
        chk_eq($sformatf("R6/R8 write count vec %0d", idx), wr_cnt, exp_wr);
        if (v.top != v.top_after) chk_eq($sformatf("R6 top written first vec %0d", idx), wr_log[0], ta);
        chk_eq($sformatf("R6 top entry after vec %0d", idx), mem[ta], v.top_after);
        chk_eq($sformatf("R6/R7 leaf entry after vec %0d", idx), mem[la], v.leaf_after);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] held_pa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk_eq("R11 req_ready after reset", {31'h0, req_ready}, 32'h1);
        chk_eq("R11 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        chk_eq("R11 mem_req_valid after reset", {31'h0, mem_req_valid}, 32'h0);

        for (int pass = 0; pass < 2; pass++) begin
            var_wait = (pass == 1);
            for (int i = 0; i < NVEC; i++) begin
                run_vec(VECS[i], i + pass * NVEC);
            end
        end

        // R9: response held under back-pressure, no new request taken
        var_wait = 1'b1;
        setup_vec(VECS[0]);
        mem[top_addr(VECS[1].vaddr)] = VECS[1].top;
        mem[leaf_addr(VECS[1].top, VECS[1].vaddr)] = VECS[1].leaf;
        rsp_ready = 1'b0;
        issue(VECS[0].vaddr, 1'b0, 1'b0);
        while (!rsp_valid) @(negedge clk);
        held_pa = rsp_paddr;
        req_valid = 1'b1;
        req_vaddr = VECS[1].vaddr;
        req_user  = 1'b1;
        req_write = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk_eq("R9 response held valid", {31'h0, rsp_valid}, 32'h1);
            chk_eq("R9 response held paddr", rsp_paddr, held_pa);
            chk_eq("R9 no accept while response waits", {31'h0, req_ready}, 32'h0);
            chk_eq("R9 no walk while response waits", {31'h0, mem_req_valid}, 32'h0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk_eq("R9 queued request served after", rsp_vaddr, VECS[1].vaddr);
        chk_eq("R9 queued request paddr", rsp_paddr, VECS[1].paddr);
        @(negedge clk);

        // R10: held memory requests under stalls
        chk_eq("R10 memory request stability errors", stab_err, 0);

        summary();
        $finish;
    end

endmodule